// File: doc/BRIEF.md
# SPI Flash Protected-Range Write Guard

This block sits between a host register bus and a SPI flash controller. It keeps a menu of eight permitted command opcodes and three address windows that can be armed against writes and erases. Each time the controller is about to start a flash operation, it presents the 24-bit flash address, a 3-bit menu index and a flag saying whether the operation modifies the flash. The guard answers in the same cycle with the opcode byte to send and a blocked flag.

A lock bit in the control register freezes the opcode menu and every window register until reset. Software sets it once its configuration is complete. Later writes to the frozen registers are dropped without any error, and reads keep returning their contents. Windows work on 4 KiB pages. The lower bound starts at the first byte of its page, and the upper bound covers all of its page.

Top module: `flash_wguard`

## Requirements
- R1: After reset the opcode menu reads 0000_0000_0000_0005h (offset 58h reads 00000005h, offset 5Ch reads 00000000h). All three window registers read 00000000h, and the lock bit (bit 15 of offset 00h) reads 0.
- R2: A window register at offset 60h, 64h or 68h reads back its write as follows: bit 31 is the arm bit, bits 23:12 are the upper page, bits 11:0 are the lower page, and bits 30:24 always read 0.
- R3: Offset 58h holds menu entries 3..0 and offset 5Ch holds entries 7..4. Entry i sits in bits 8(i mod 4)+7 : 8(i mod 4) of its word.
- R4: `req_opcode` equals the menu entry selected by `req_idx`, in the same cycle.
- R5: An armed window hits when lower ≤ addr[23:12] ≤ upper. The whole upper page is covered, and the first byte of the page after it is not covered.
- R6: A window whose arm bit is 0 never causes a block, whatever its page fields hold.
- R7: For a modifying request, `req_blocked` is the OR of the hits of all three windows.
- R8: When `req_is_write` is 0, `req_blocked` is 0.
- R9: Writing 1 to bit 15 of offset 00h sets the lock. The lock stays set until reset, and writing 0 to it has no effect.
- R10: While the lock is set, writes to offsets 58h, 5Ch, 60h, 64h and 68h are ignored, and reads still return the stored values.
- R11: A register write takes effect for reads and requests from the cycle after its write edge. Offsets that are not mapped, and unused control bits, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| req_addr | input | 24 | Flash address of the pending operation |
| req_idx | input | 3 | Opcode menu index |
| req_is_write | input | 1 | 1 = write or erase, 0 = read |
| req_opcode | output | 8 | Opcode byte to issue |
| req_blocked | output | 1 | Operation falls inside an armed window |

## Verification
`req_opcode`, `req_blocked` and `reg_rdata` are combinational, so they are due in the same cycle as the inputs that select them. A register write is due one cycle later, after the rising edge that stores it. The bench changes all inputs on the falling edge and compares the outputs against its behavioural model 1 ns later. It applies each write to the model only after the following rising edge. The model therefore shows a write from the next cycle on, as R11 requires.

// File: rtl/fwg_pkg.sv
package fwg_pkg;

    localparam int REG_AW     = 8;
    localparam int DATA_W     = 32;
    localparam int PAGE_W     = 12;
    localparam int FLASH_AW   = 24;
    localparam int LOCK_BIT   = 15;

    localparam logic [REG_AW-1:0] OFS_CTRL    = 8'h00;
    localparam logic [REG_AW-1:0] OFS_MENU    = 8'h58;
    localparam logic [REG_AW-1:0] OFS_WINDOW  = 8'h60;

    localparam logic [63:0] MENU_RESET = 64'h0000_0000_0000_0005;

    typedef struct packed {
        logic              armed;
        logic [PAGE_W-1:0] upper;
        logic [PAGE_W-1:0] lower;
    } window_t;

    function automatic logic [DATA_W-1:0] window_to_word(window_t w);
        return {w.armed, 7'b0, w.upper, w.lower};
    endfunction

    function automatic window_t word_to_window(logic [DATA_W-1:0] d);
        window_t w;
        w.armed = d[31];
        w.upper = d[23:12];
        w.lower = d[11:0];
        return w;
    endfunction

    function automatic logic window_hit(window_t w, logic [PAGE_W-1:0] page);
        return w.armed && (page >= w.lower) && (page <= w.upper);
    endfunction

endpackage

// File: rtl/fwg_regs.sv
module fwg_regs
    import fwg_pkg::*;
#(
    parameter int NUM_WIN = 3,
    parameter int NUM_OPS = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [REG_AW-1:0]         addr,
    input  logic [DATA_W-1:0]         wdata,
    output logic [DATA_W-1:0]         rdata,
    output logic [NUM_OPS*8-1:0]      menu,
    output window_t [NUM_WIN-1:0]     windows,
    output logic                      lock
);
    localparam int MENU_W     = NUM_OPS * 8;
    localparam int MENU_WORDS = MENU_W / DATA_W;

    logic [DATA_W-1:0] menu_w [MENU_WORDS];
    window_t           win_q  [NUM_WIN];
    logic              lock_q;

    always_ff @(posedge clk) begin
        if (rst)
            lock_q <= 1'b0;
        else if (wr_en && addr == OFS_CTRL && wdata[LOCK_BIT])
            lock_q <= 1'b1;
    end

    for (genvar w = 0; w < MENU_WORDS; w++) begin : g_menu
        localparam logic [REG_AW-1:0] OFS = OFS_MENU + REG_AW'(4 * w);
        always_ff @(posedge clk) begin
            if (rst)
                menu_w[w] <= MENU_RESET[w*DATA_W +: DATA_W];
            else if (wr_en && !lock_q && addr == OFS)
                menu_w[w] <= wdata;
        end
        assign menu[w*DATA_W +: DATA_W] = menu_w[w];
    end

    for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
        localparam logic [REG_AW-1:0] OFS = OFS_WINDOW + REG_AW'(4 * k);
        always_ff @(posedge clk) begin
            if (rst)
                win_q[k] <= '0;
            else if (wr_en && !lock_q && addr == OFS)
                win_q[k] <= word_to_window(wdata);
        end
        assign windows[k] = win_q[k];
    end

    always_comb begin
        rdata = '0;
        if (addr == OFS_CTRL)
            rdata[LOCK_BIT] = lock_q;
        for (int w = 0; w < MENU_WORDS; w++)
            if (addr == OFS_MENU + REG_AW'(4 * w))
                rdata = menu_w[w];
        for (int k = 0; k < NUM_WIN; k++)
            if (addr == OFS_WINDOW + REG_AW'(4 * k))
                rdata = window_to_word(win_q[k]);
    end

    assign lock = lock_q;

endmodule

// File: rtl/fwg_window_chk.sv
module fwg_window_chk
    import fwg_pkg::*;
#(
    parameter int NUM_WIN = 3
) (
    input  window_t [NUM_WIN-1:0] windows,
    input  logic [PAGE_W-1:0]     page,
    output logic [NUM_WIN-1:0]    hit
);
    for (genvar k = 0; k < NUM_WIN; k++) begin : g_hit
        assign hit[k] = window_hit(windows[k], page);
    end
endmodule

// File: rtl/fwg_opsel.sv
module fwg_opsel #(
    parameter int NUM_OPS = 8,
    parameter int IDX_W   = $clog2(NUM_OPS)
) (
    input  logic [NUM_OPS*8-1:0] menu,
    input  logic [IDX_W-1:0]     idx,
    output logic [7:0]           opcode
);
    logic [7:0] entry [NUM_OPS];

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_entry
        assign entry[i] = menu[i*8 +: 8];
    end

    assign opcode = entry[idx];
endmodule

// File: rtl/flash_wguard.sv
module flash_wguard
    import fwg_pkg::*;
#(
    parameter int NUM_WIN = 3,
    parameter int NUM_OPS = 8,
    localparam int IDX_W  = $clog2(NUM_OPS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [FLASH_AW-1:0] req_addr,
    input  logic [IDX_W-1:0]    req_idx,
    input  logic                req_is_write,
    output logic [7:0]          req_opcode,
    output logic                req_blocked
);
    logic [NUM_OPS*8-1:0]  menu;
    window_t [NUM_WIN-1:0] windows;
    logic                  lock;
    logic [NUM_WIN-1:0]    hit;
    logic [NUM_WIN-1:0]    win_armed;

    fwg_regs #(.NUM_WIN(NUM_WIN), .NUM_OPS(NUM_OPS)) i_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .menu    (menu),
        .windows (windows),
        .lock    (lock)
    );

    fwg_window_chk #(.NUM_WIN(NUM_WIN)) i_chk_win (
        .windows (windows),
        .page    (req_addr[FLASH_AW-1 -: PAGE_W]),
        .hit     (hit)
    );

    fwg_opsel #(.NUM_OPS(NUM_OPS), .IDX_W(IDX_W)) i_opsel (
        .menu   (menu),
        .idx    (req_idx),
        .opcode (req_opcode)
    );

    for (genvar k = 0; k < NUM_WIN; k++) begin : g_armed
        assign win_armed[k] = windows[k].armed;
    end

    assign req_blocked = req_is_write && (|hit);

endmodule

// File: rtl/fwg_checker.sv
module fwg_checker #(
    parameter int NUM_WIN = 3,
    parameter int MENU_W  = 64,
    parameter int WIN_W   = 75
) (
    input logic              clk,
    input logic              rst,
    input logic              lock,
    input logic [MENU_W-1:0] menu,
    input logic [WIN_W-1:0]  win_bits,
    input logic [NUM_WIN-1:0] win_armed,
    input logic              req_is_write,
    input logic              req_blocked
);
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (menu == MENU_W'(5) && !lock && win_bits == '0)); // R1

    AST_DISARMED_NO_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (win_armed == '0) |-> !req_blocked); // R6

    AST_READ_NEVER_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        !req_is_write |-> !req_blocked); // R8

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        lock |=> lock); // R9

    AST_LOCKED_MENU_FROZEN: assert property (@(posedge clk) disable iff (rst)
        lock |=> $stable(menu)); // R10

    AST_LOCKED_WINDOWS_FROZEN: assert property (@(posedge clk) disable iff (rst)
        lock |=> $stable(win_bits)); // R10
endmodule

bind flash_wguard fwg_checker #(
    .NUM_WIN (NUM_WIN),
    .MENU_W  (NUM_OPS * 8),
    .WIN_W   ($bits(windows))
) i_fwg_checker (
    .clk          (clk),
    .rst          (rst),
    .lock         (lock),
    .menu         (menu),
    .win_bits     (windows),
    .win_armed    (win_armed),
    .req_is_write (req_is_write),
    .req_blocked  (req_blocked)
);

// File: tb/test_flash_wguard.sv
`timescale 1ns/1ps
module test_flash_wguard;
    logic        clk = 0;
    logic        rst = 1;
    logic        reg_wr = 0;
    logic [7:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic [23:0] req_addr = 0;
    logic [2:0]  req_idx = 0;
    logic        req_is_write = 0;
    logic [7:0]  req_opcode;
    logic        req_blocked;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    flash_wguard i_flash_wguard (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_addr(req_addr),
        .req_idx(req_idx), .req_is_write(req_is_write),
        .req_opcode(req_opcode), .req_blocked(req_blocked)
    );

    // behavioural reference model
    logic [7:0]  m_menu [8];
    logic        m_arm  [3];
    logic [11:0] m_up   [3];
    logic [11:0] m_lo   [3];
    logic        m_lock;

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_menu[i] = 8'h00;
        m_menu[0] = 8'h05;
        for (int k = 0; k < 3; k++) begin
            m_arm[k] = 0; m_up[k] = 0; m_lo[k] = 0;
        end
        m_lock = 0;
    endtask

    function automatic logic [31:0] model_read(logic [7:0] a);
        if (a == 8'h00) return {16'h0, m_lock, 15'h0};
        if (a == 8'h58) return {m_menu[3], m_menu[2], m_menu[1], m_menu[0]};
        if (a == 8'h5C) return {m_menu[7], m_menu[6], m_menu[5], m_menu[4]};
        for (int k = 0; k < 3; k++)
            if (a == 8'h60 + 8'(4 * k)) return {m_arm[k], 7'h0, m_up[k], m_lo[k]};
        return 32'h0;
    endfunction

    task automatic model_write(logic [7:0] a, logic [31:0] d);
        if (a == 8'h00) begin
            if (d[15]) m_lock = 1;
        end else if (!m_lock) begin
            if (a == 8'h58) for (int i = 0; i < 4; i++) m_menu[i]   = d[8*i +: 8];
            if (a == 8'h5C) for (int i = 0; i < 4; i++) m_menu[4+i] = d[8*i +: 8];
            for (int k = 0; k < 3; k++)
                if (a == 8'h60 + 8'(4 * k)) begin
                    m_arm[k] = d[31]; m_up[k] = d[23:12]; m_lo[k] = d[11:0];
                end
        end
    endtask

    function automatic logic model_blocked(logic [23:0] fa, logic isw);
        logic b = 0;
        if (!isw) return 0;
        for (int k = 0; k < 3; k++)
            if (m_arm[k] && fa[23:12] >= m_lo[k] && fa[23:12] <= m_up[k]) b = 1;
        return b;
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // drive at falling edge, compare 1 ns later, apply write to model after rising edge
    task automatic step(string tag, bit we, logic [7:0] ra, logic [31:0] wd,
                        logic [23:0] fa, logic [2:0] ix, bit isw);
        @(negedge clk);
        reg_wr = we; reg_addr = ra; reg_wdata = wd;
        req_addr = fa; req_idx = ix; req_is_write = isw;
        #1;
        check(tag, "rdata",   reg_rdata,          model_read(ra));
        check(tag, "opcode",  {24'h0, req_opcode}, {24'h0, m_menu[ix]});
        check(tag, "blocked", {31'h0, req_blocked}, {31'h0, model_blocked(fa, isw)});
        @(posedge clk);
        if (we) model_write(ra, wd);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1: reset state
        step("R1", 0, 8'h00, 0, 24'h0, 0, 1);
        step("R1", 0, 8'h58, 0, 24'h0, 0, 1);
        step("R1", 0, 8'h5C, 0, 24'h0, 1, 1);
        step("R1", 0, 8'h60, 0, 24'h0, 0, 1);
        step("R1", 0, 8'h64, 0, 24'h0, 0, 1);
        step("R1", 0, 8'h68, 0, 24'h0, 0, 1);

        // R3: menu layout; R11: visible next cycle
        step("R3", 1, 8'h58, 32'h20D8_0602, 24'h0, 0, 0);
        step("R11", 1, 8'h5C, 32'hC7AB_5290, 24'h0, 1, 0);
        step("R3", 0, 8'h58, 0, 24'h0, 2, 0);
        step("R3", 0, 8'h5C, 0, 24'h0, 3, 0);
        // R4: opcode select sweep
        for (int i = 0; i < 8; i++) step("R4", 0, 8'h5C, 0, 24'h0, 3'(i), 1);

        // R2: window field layout, reserved bits read 0
        step("R2", 1, 8'h60, 32'hFF01_2010, 24'h0, 0, 1);
        step("R2", 0, 8'h60, 0, 24'h0, 0, 1);
        // R5: boundaries of window 0 (pages 010h..012h)
        step("R5", 0, 8'h60, 0, 24'h00FFFF, 0, 1);
        step("R5", 0, 8'h60, 0, 24'h010000, 0, 1);
        step("R5", 0, 8'h60, 0, 24'h012FFF, 0, 1);
        step("R5", 0, 8'h60, 0, 24'h013000, 0, 1);
        // R8: reads never blocked
        step("R8", 0, 8'h60, 0, 24'h011000, 4, 0);
        step("R8", 0, 8'h60, 0, 24'h012FFF, 5, 0);
        // R6: disarmed window covering everything
        step("R6", 1, 8'h64, 32'h7FFF_F000, 24'h500000, 0, 1);
        step("R6", 0, 8'h64, 0, 24'h500000, 0, 1);
        step("R6", 0, 8'h64, 0, 24'hABCDEF, 0, 1);
        // R7: OR across windows
        step("R7", 1, 8'h68, 32'h8040_0400, 24'h0, 0, 1);
        step("R7", 0, 8'h68, 0, 24'h400123, 0, 1);
        step("R7", 0, 8'h68, 0, 24'h010500, 0, 1);
        step("R7", 0, 8'h68, 0, 24'h401000, 0, 1);
        for (int i = 0; i < 300; i++)
            step("R7", 0, 8'h68, 0, 24'($urandom) & 24'h41FFFF, 3'($urandom), 1'($urandom));
        // R11: unmapped offsets
        step("R11", 0, 8'h70, 0, 24'h0, 0, 0);
        step("R11", 0, 8'h04, 0, 24'h0, 0, 0);
        step("R11", 0, 8'h54, 0, 24'h0, 0, 0);

        // R9: lock set and sticky
        step("R9", 1, 8'h00, 32'h0000_0000, 24'h0, 0, 0);
        step("R9", 1, 8'h00, 32'h0000_8000, 24'h0, 0, 0);
        step("R9", 1, 8'h00, 32'h0000_0000, 24'h0, 0, 0);
        step("R9", 0, 8'h00, 0, 24'h0, 0, 0);
        // R10: frozen registers
        step("R10", 1, 8'h58, 32'hFFFF_FFFF, 24'h0, 0, 0);
        step("R10", 1, 8'h5C, 32'h1111_1111, 24'h0, 6, 0);
        step("R10", 1, 8'h60, 32'h0000_0000, 24'h0, 0, 0);
        step("R10", 1, 8'h68, 32'h0000_0000, 24'h0, 0, 0);
        step("R10", 0, 8'h58, 0, 24'h010000, 1, 1);
        step("R10", 0, 8'h5C, 0, 24'h400000, 7, 1);
        step("R10", 0, 8'h60, 0, 24'h011000, 0, 1);
        step("R10", 0, 8'h68, 0, 24'h400FFF, 0, 1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule